// File: doc/BRIEF.md
# Serial-to-Bus Debug Bridge

This block lets a host computer peek and poke a chip's internal 32-bit memory-mapped bus through a single asynchronous serial pair. Bytes arriving on the receive line are framed by an 8N1 receiver running at a fixed number of clocks per bit. A command parser turns them into single-word bus accesses. A read returns its word to the host through a matching transmitter.

The host sends a sync byte 0x55 once to start the link. The parser ignores it. A write is the opcode 0xC0, then four address bytes, then four data bytes. A read is the opcode 0x80, then four address bytes, and the bridge answers with four bytes of read data. Every multi-byte field is sent most significant byte first. Bus accesses are always word aligned.

A request is held on the bus until the target raises `bus_ready_i`. On that cycle the read data is captured and the parser moves on.

Top module: `uart_bus_bridge`

## Requirements
- R1: Both serial directions use one start bit (low), eight data bits sent least significant bit first, and one stop bit (high), each lasting CLKS_PER_BIT clocks; the transmit line stays high while nothing is being sent.
- R2: The receiver checks the start bit at its middle; a low pulse on the receive line shorter than half a bit is discarded and produces no byte.
- R3: A received 0x55 while the parser is idle causes no bus access and no transmitted byte, and the parser stays idle.
- R4: Any other idle-state byte that is neither 0x80 nor 0xC0 is likewise dropped, and a valid command right after it is handled normally.
- R5: 0xC0 followed by address bytes A31..A24, A23..A16, A15..A8, A7..A0 and then data bytes D31..D24 down to D7..D0 produces exactly one bus write, with bus_we_o asserted only after the fourth data byte, carrying that address and that data.
- R6: Bits 1:0 of bus_addr_o are zero whenever a request is active, whatever the host sent in the last address byte.
- R7: 0x80 followed by four address bytes, most significant first, produces exactly one bus read request after the fourth address byte.
- R8: A request holds its address and stays asserted until bus_ready_i is high; it is dropped on the cycle after that, and bus_we_o and bus_re_o are never high together.
- R9: For a read, the value on bus_rdata_i in the ready cycle is returned on the transmit line as four bytes, bits 31:24 first and bits 7:0 last, and a new byte is started only when the transmitter is idle.
- R10: With rst_n low at a clock edge, the transmit line goes high, both requests are cleared and any partly received command is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uart_rx_i | input | 1 | Serial receive line from host |
| uart_tx_o | output | 1 | Serial transmit line to host |
| bus_addr_o | output | 32 | Word-aligned access address |
| bus_wdata_o | output | 32 | Write data |
| bus_we_o | output | 1 | Write request, held until ready |
| bus_re_o | output | 1 | Read request, held until ready |
| bus_ready_i | input | 1 | Target completes the current access |
| bus_rdata_i | input | 32 | Read data, valid with bus_ready_i |

## Verification
On every cycle, the assertions check that the two requests are exclusive and that a pending request keeps its address until ready. They also check that the request drops after ready, that the address is aligned, and that the transmitter is only started while idle. The ignore rules for sync and unknown bytes, the rejection of short start glitches, the byte order of both directions and the abandoning of a command on reset are shown only by the bench's scenarios. The bench decodes the transmit line independently and matches the bus transactions against its expected queues.

// File: rtl/ubb_pkg.sv
package ubb_pkg;
  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [7:0] OP_READ   = 8'h80;
  localparam logic [7:0] OP_WRITE  = 8'hC0;

  typedef enum logic [2:0] {
    PS_IDLE, PS_ADDR, PS_DATA, PS_WACC, PS_RACC, PS_SEND
  } pstate_t;

  function automatic logic [31:0] word_align(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] i);
    case (i)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction
endpackage

// File: rtl/ubb_uart_rx.sv
module ubb_uart_rx #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  output logic       byte_valid_o,
  output logic [7:0] byte_o
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] MID  = CW'(CLKS_PER_BIT / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxs_t;
  rxs_t st;
  logic [1:0] sync_q;
  logic [CW-1:0] cnt;
  logic [2:0] bit_idx;
  logic [7:0] shreg;
  logic line;

  assign line = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= 2'b11; st <= RX_IDLE; cnt <= '0; bit_idx <= '0;
      shreg <= '0; byte_valid_o <= 1'b0; byte_o <= '0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      byte_valid_o <= 1'b0;
      case (st)
        RX_IDLE: if (!line) begin st <= RX_START; cnt <= '0; end
        RX_START:
          if (cnt == MID) begin
            cnt <= '0; bit_idx <= '0;
            st <= line ? RX_IDLE : RX_DATA;
          end else cnt <= cnt + 1'b1;
        RX_DATA:
          if (cnt == LAST) begin
            cnt <= '0;
            shreg <= {line, shreg[7:1]};
            if (bit_idx == 3'd7) st <= RX_STOP;
            bit_idx <= bit_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        default:
          if (cnt == LAST) begin
            cnt <= '0; st <= RX_IDLE;
            if (line) begin byte_valid_o <= 1'b1; byte_o <= shreg; end
          end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |=> !byte_valid_o);
endmodule

// File: rtl/ubb_uart_tx.sv
module ubb_uart_tx #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  output logic       busy_o,
  output logic       tx_o
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt;
  logic [3:0] idx;
  logic [8:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0; tx_o <= 1'b1; cnt <= '0; idx <= '0; sr <= '1;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1; tx_o <= 1'b0; cnt <= '0; idx <= '0;
        sr <= {1'b1, byte_i};
      end
    end else if (cnt == LAST) begin
      cnt <= '0;
      if (idx == 4'd9) busy_o <= 1'b0;
      else begin
        tx_o <= sr[0];
        sr <= {1'b1, sr[8:1]};
        idx <= idx + 1'b1;
      end
    end else cnt <= cnt + 1'b1;
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> tx_o);
  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/ubb_cmd_parser.sv
module ubb_cmd_parser
  import ubb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_byte_i,
  input  logic        tx_busy_i,
  output logic        tx_start_o,
  output logic [7:0]  tx_byte_o,
  output logic [31:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  output logic        bus_we_o,
  output logic        bus_re_o,
  input  logic        bus_ready_i,
  input  logic [31:0] bus_rdata_i
);
  pstate_t st;
  logic [1:0] cnt;
  logic is_write, sent_all;
  logic [31:0] addr_q, data_q, rdata_q;
  logic req_active;

  assign bus_we_o    = (st == PS_WACC);
  assign bus_re_o    = (st == PS_RACC);
  assign bus_addr_o  = word_align(addr_q);
  assign bus_wdata_o = data_q;
  assign req_active  = bus_we_o | bus_re_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PS_IDLE; cnt <= '0; is_write <= 1'b0; sent_all <= 1'b0;
      addr_q <= '0; data_q <= '0; rdata_q <= '0;
      tx_start_o <= 1'b0; tx_byte_o <= '0;
    end else begin
      tx_start_o <= 1'b0;
      case (st)
        PS_IDLE:
          if (rx_valid_i) begin
            cnt <= '0;
            if (rx_byte_i == OP_WRITE)     begin is_write <= 1'b1; st <= PS_ADDR; end
            else if (rx_byte_i == OP_READ) begin is_write <= 1'b0; st <= PS_ADDR; end
          end
        PS_ADDR:
          if (rx_valid_i) begin
            addr_q <= {addr_q[23:0], rx_byte_i};
            cnt <= cnt + 1'b1;
            if (cnt == 2'd3) st <= is_write ? PS_DATA : PS_RACC;
          end
        PS_DATA:
          if (rx_valid_i) begin
            data_q <= {data_q[23:0], rx_byte_i};
            cnt <= cnt + 1'b1;
            if (cnt == 2'd3) st <= PS_WACC;
          end
        PS_WACC:
          if (bus_ready_i) st <= PS_IDLE;
        PS_RACC:
          if (bus_ready_i) begin
            rdata_q <= bus_rdata_i; cnt <= '0; sent_all <= 1'b0; st <= PS_SEND;
          end
        default:
          if (!tx_busy_i && !tx_start_o) begin
            if (sent_all) st <= PS_IDLE;
            else begin
              tx_start_o <= 1'b1;
              tx_byte_o <= pick_byte(rdata_q, cnt);
              cnt <= cnt + 1'b1;
              if (cnt == 2'd3) sent_all <= 1'b1;
            end
          end
      endcase
    end
  end

  assert_one_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we_o && bus_re_o));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_active && !bus_ready_i) |=> (req_active && $stable(bus_addr_o)));
  assert_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_active && bus_ready_i) |=> !req_active);
  assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_active |-> (bus_addr_o[1:0] == 2'b00));
endmodule

// File: rtl/uart_bus_bridge.sv
module uart_bus_bridge #(
  parameter int CLKS_PER_BIT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        uart_rx_i,
  output logic        uart_tx_o,
  output logic [31:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  output logic        bus_we_o,
  output logic        bus_re_o,
  input  logic        bus_ready_i,
  input  logic [31:0] bus_rdata_i
);
  logic       rx_valid, tx_start, tx_busy;
  logic [7:0] rx_byte, tx_byte;

  ubb_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(uart_rx_i),
    .byte_valid_o(rx_valid), .byte_o(rx_byte));

  ubb_cmd_parser u_parse (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .tx_busy_i(tx_busy), .tx_start_o(tx_start), .tx_byte_o(tx_byte),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_we_o(bus_we_o), .bus_re_o(bus_re_o),
    .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i));

  ubb_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .start_i(tx_start), .byte_i(tx_byte),
    .busy_o(tx_busy), .tx_o(uart_tx_o));
endmodule

// File: tb/sim_uart_bus_bridge.sv
module sim_uart_bus_bridge;
  localparam int CPB = 8;
  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1, ready = 1'b0;
  logic [31:0] rdata = '0;
  logic tx, we, re;
  logic [31:0] addr, wdata;
  int total = 0, bad = 0, lat = 0, wait_cnt = 0;
  logic [31:0] cap_addr;
  logic [31:0] wa_q[$], wd_q[$], ra_q[$];
  logic [7:0] txq[$];
  logic [31:0] rd_value = 32'hCAFE_0102;
  bit finished = 0;

  always #4 clk = ~clk;

  uart_bus_bridge #(.CLKS_PER_BIT(CPB)) u0 (
    .clk(clk), .rst_n(rst_n), .uart_rx_i(rx), .uart_tx_o(tx),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_we_o(we), .bus_re_o(re),
    .bus_ready_i(ready), .bus_rdata_i(rdata));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx = b[i]; repeat (CPB) @(negedge clk); end
    rx = 1'b1; repeat (CPB) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[8*i +: 8]);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0; rx = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // bus target model, compared every cycle
  initial begin
    forever begin
      @(negedge clk);
      chk(!(we && re), "R8 exclusive requests", {30'd0, we, re}, 32'd0);
      if (!rst_n) begin ready = 1'b0; wait_cnt = 0; end
      else if (ready) begin
        ready = 1'b0; wait_cnt = 0;
        chk(!(we || re), "R8 request dropped after ready", {30'd0, we, re}, 32'd0);
      end else if (we || re) begin
        if (wait_cnt == 0) cap_addr = addr;
        else chk(addr == cap_addr, "R8 address held", addr, cap_addr);
        chk(addr[1:0] == 2'b00, "R6 aligned address", addr, {addr[31:2], 2'b00});
        if (wait_cnt == lat) begin
          ready = 1'b1;
          if (we) begin wa_q.push_back(addr); wd_q.push_back(wdata); end
          else begin ra_q.push_back(addr); rdata = rd_value; end
        end else wait_cnt++;
      end
    end
  end

  // independent serial decoder for the transmit line
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && tx === 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        if (tx === 1'b0) begin
          for (int i = 0; i < 8; i++) begin repeat (CPB) @(negedge clk); b[i] = tx; end
          repeat (CPB) @(negedge clk);
          chk(tx === 1'b1, "R1 stop bit high", {31'd0, tx}, 32'd1);
          txq.push_back(b);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(tx === 1'b1, "R10 tx high after reset", {31'd0, tx}, 32'd1);
    chk(we === 1'b0 && re === 1'b0, "R10 no request after reset", {30'd0, we, re}, 32'd0);

    // sync byte ignored
    send_byte(8'h55); repeat (40) @(negedge clk);
    chk(wa_q.size() + ra_q.size() == 0, "R3 sync causes no access", wa_q.size() + ra_q.size(), 0);
    chk(txq.size() == 0, "R3 sync causes no reply", txq.size(), 0);

    // unknown bytes dropped, then a write with misaligned low address bits
    send_byte(8'h13); send_byte(8'hFF);
    repeat (20) @(negedge clk);
    chk(wa_q.size() + ra_q.size() == 0, "R4 unknown bytes dropped", wa_q.size() + ra_q.size(), 0);
    lat = 0;
    send_byte(8'hC0); send_word(32'h1234_567B);
    send_byte(8'hDE); send_byte(8'hAD); send_byte(8'hBE);
    repeat (10) @(negedge clk);
    chk(wa_q.size() == 0, "R5 no write before fourth data byte", wa_q.size(), 0);
    send_byte(8'hEF); repeat (20) @(negedge clk);
    chk(wa_q.size() == 1, "R5 one write", wa_q.size(), 1);
    if (wa_q.size() > 0) begin
      chk(wa_q[0] == 32'h1234_5678, "R6 write address aligned", wa_q[0], 32'h1234_5678);
      chk(wd_q[0] == 32'hDEAD_BEEF, "R5 write data", wd_q[0], 32'hDEAD_BEEF);
    end
    wa_q.delete(); wd_q.delete();

    // write with wait states
    lat = 4;
    send_byte(8'hC0); send_word(32'hA000_0010); send_word(32'h0102_0304);
    repeat (30) @(negedge clk);
    chk(wa_q.size() == 1, "R8 write completes after wait states", wa_q.size(), 1);
    if (wa_q.size() > 0) chk(wd_q[0] == 32'h0102_0304, "R5 write data with wait", wd_q[0], 32'h0102_0304);
    wa_q.delete(); wd_q.delete();

    // read
    lat = 2; rd_value = 32'hCAFE_0102;
    send_byte(8'h80); send_word(32'h0000_1003);
    repeat (30) @(negedge clk);
    chk(ra_q.size() == 1, "R7 one read", ra_q.size(), 1);
    if (ra_q.size() > 0) chk(ra_q[0] == 32'h0000_1000, "R7 read address", ra_q[0], 32'h0000_1000);
    repeat (450) @(negedge clk);
    chk(txq.size() == 4, "R9 four reply bytes", txq.size(), 4);
    if (txq.size() == 4)
      chk({txq[0], txq[1], txq[2], txq[3]} == 32'hCAFE_0102, "R9 reply order",
          {txq[0], txq[1], txq[2], txq[3]}, 32'hCAFE_0102);
    txq.delete(); ra_q.delete();

    // false start glitch, then a read proves receiver recovered
    @(negedge clk) rx = 1'b0; repeat (CPB / 4) @(negedge clk); rx = 1'b1;
    repeat (40) @(negedge clk);
    chk(wa_q.size() + ra_q.size() + txq.size() == 0, "R2 glitch ignored",
        wa_q.size() + ra_q.size() + txq.size(), 0);
    lat = 0; rd_value = 32'h8877_6655;
    send_byte(8'h80); send_word(32'h0000_0040);
    repeat (480) @(negedge clk);
    chk(ra_q.size() == 1, "R2 read after glitch", ra_q.size(), 1);
    if (txq.size() == 4)
      chk({txq[0], txq[1], txq[2], txq[3]} == 32'h8877_6655, "R9 second reply",
          {txq[0], txq[1], txq[2], txq[3]}, 32'h8877_6655);
    else chk(0, "R9 second reply count", txq.size(), 4);
    txq.delete(); ra_q.delete();

    // reset abandons partial write
    send_byte(8'hC0); send_byte(8'h12); send_byte(8'h34);
    do_reset();
    send_byte(8'h80); send_word(32'h0000_0100);
    repeat (30) @(negedge clk);
    chk(wa_q.size() == 0, "R10 partial write abandoned", wa_q.size(), 0);
    chk(ra_q.size() == 1, "R10 command after reset handled", ra_q.size(), 1);
    if (ra_q.size() > 0) chk(ra_q[0] == 32'h0000_0100, "R10 address after reset", ra_q[0], 32'h0000_0100);
    repeat (450) @(negedge clk);
    chk(tx === 1'b1, "R1 line idles high", {31'd0, tx}, 32'd1);
    summary();
  end
endmodule